// File: doc/BRIEF.md
# RV32I Integer Decode and Execute Stage

This block takes one 32-bit base-integer instruction, the address it was fetched from and the two source register values. From them it works out the register write-back (enable, index, data), the address of the next instruction, a word memory request (address, store data, read or write strobe) and a flag for an instruction it does not implement. The register file and the memory sit outside the block. A fetch/issue stage presents an instruction and its operands. The outputs are registered, so the register file, the memory port and the fetch unit take their controls one clock after the instruction was presented.

The stage covers register-register and register-immediate arithmetic, both upper-immediate forms, both jumps, all six conditional branches, and word loads and stores. Each instruction format scatters its immediate bits differently, and the block rebuilds every immediate itself. Multiply/divide encodings, narrow loads and stores, system encodings and unknown opcodes raise the illegal flag. They then leave the register file and the memory untouched. For a load, the block puts out the destination index with the write enable. The data written comes from the memory's read response, so the write-data output stays zero for loads.

Top module: `rvx_exec_unit`

## Requirements
- R1: Every output is a register. The result for the inputs sampled at a rising clock edge appears just after that edge. While the active-low reset is asserted, every output is zero.
- R2: Immediates are sign-extended from bit 31. I = inst[31:20]. S = {inst[31:25], inst[11:7]}. B = {inst[31], inst[7], inst[30:25], inst[11:8], 0}. J = {inst[31], inst[19:12], inst[20], inst[30:21], 0}. U = {inst[31:12], 12 zeros}.
- R3: Opcode 0110111 writes the U immediate to rd. Opcode 0010111 writes pc + U immediate to rd.
- R4: Opcode 0110011 with funct7 0000000 selects an operation by funct3 on rs1 and rs2: 000 add, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 logical right shift, 110 or, 111 and. Shifts use rs2[4:0]. With funct7 0100000, funct3 000 subtracts and 101 shifts right arithmetically.
- R5: Opcode 0010011 applies the same funct3 operations to rs1 and the I immediate. There is no subtract form. For 001 and 101 the shift amount is imm[4:0]; inst[31:25] must be 0000000, or 0100000 for an arithmetic right shift with 101.
- R6: Opcode 1101111 writes pc+4 to rd and jumps to pc + J immediate. Opcode 1100111 with funct3 000 writes pc+4 to rd and jumps to rs1 + I immediate, with bit 0 cleared.
- R7: Opcode 1100011 jumps to pc + B immediate when the compare holds, and otherwise goes to pc+4. The funct3 codes are 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal.
- R8: Opcode 0000011 with funct3 010 raises the read strobe at rs1 + I immediate and enables the write to rd with zero write data. Opcode 0100011 with funct3 010 raises the write strobe at rs1 + S immediate with rs2 as data. At most one strobe is high. The address and store data are zero when no strobe is high.
- R9: The illegal flag rises, and no register write or memory strobe occurs, for: register ops with any other funct7 (including the multiply/divide funct7 0000001), bad shift-immediate upper bits, the jump-register form with funct3 other than 000, branch funct3 010/011, load or store funct3 other than 010, and any other opcode.
- R10: A destination of x0 produces no write. The write enable, index and data all read zero.
- R11: Every instruction that is not a taken branch or a jump, including illegal ones, gives pc+4 modulo 2^32 as the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| rd_we | output | 1 | Register write enable |
| rd_addr | output | 5 | Register write index |
| rd_data | output | 32 | Register write data |
| next_pc | output | 32 | Address of the next instruction |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | 32 | Word access address |
| mem_wdata | output | 32 | Store data |
| illegal | output | 1 | Unimplemented-instruction flag |

## Verification
The bench builds the block at its only configuration, 32-bit data and five-bit register indices, because the encodings are fixed by the instruction format. For register and immediate operations, it sweeps every funct3 against the three funct7 choices (plain, alternate, multiply) and eight corner operands: zero, one, all ones, the sign bit alone, the largest positive value, and shift-edge values. Every opcode-level legality case and the signed versus unsigned difference of each compare are therefore exercised. For the branch, jump and memory forms, the bench walks immediates that set each scattered field at its extremes: the most negative and most positive offsets, and the lone bit 11. This exposes a misplaced immediate bit.

// File: rtl/rvx_pkg.sv
package rvx_pkg;

    localparam int unsigned XLEN    = 32;
    localparam int unsigned ILEN    = 32;
    localparam int unsigned REG_AW  = 5;
    localparam int unsigned SHAMT_W = $clog2(XLEN);
    localparam int unsigned NUM_IMM = 5;

    typedef enum logic [6:0] {
        OPC_LOAD   = 7'b0000011,
        OPC_OPIMM  = 7'b0010011,
        OPC_AUIPC  = 7'b0010111,
        OPC_STORE  = 7'b0100011,
        OPC_OP     = 7'b0110011,
        OPC_LUI    = 7'b0110111,
        OPC_BRANCH = 7'b1100011,
        OPC_JALR   = 7'b1100111,
        OPC_JAL    = 7'b1101111
    } opcode_e;

    typedef enum int unsigned {
        IMM_I = 0,
        IMM_S = 1,
        IMM_B = 2,
        IMM_U = 3,
        IMM_J = 4
    } imm_kind_e;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLL,
        ALU_SLT,
        ALU_SLTU,
        ALU_XOR,
        ALU_SRL,
        ALU_SRA,
        ALU_OR,
        ALU_AND
    } alu_op_e;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;
    localparam logic [2:0] F3_WORD = 3'b010;

    typedef struct packed {
        logic              rd_we;
        logic [REG_AW-1:0] rd_addr;
        logic [XLEN-1:0]   rd_data;
        logic [XLEN-1:0]   next_pc;
        logic              mem_rd;
        logic              mem_wr;
        logic [XLEN-1:0]   mem_addr;
        logic [XLEN-1:0]   mem_wdata;
        logic              illegal;
    } exec_res_t;

endpackage

// File: rtl/rvx_imm_gen.sv
module rvx_imm_gen
    import rvx_pkg::*;
#(
    parameter imm_kind_e KIND = IMM_I
) (
    input  logic [ILEN-1:0] instr,
    output logic [XLEN-1:0] imm
);

    generate
        if (KIND == IMM_I) begin : g_i
            assign imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
        end else if (KIND == IMM_S) begin : g_s
            assign imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
        end else if (KIND == IMM_B) begin : g_b
            assign imm = {{(XLEN-12){instr[31]}}, instr[7], instr[30:25],
                          instr[11:8], 1'b0};
        end else if (KIND == IMM_U) begin : g_u
            assign imm = {instr[31:12], 12'b0};
        end else begin : g_j
            assign imm = {{(XLEN-20){instr[31]}}, instr[19:12], instr[20],
                          instr[30:21], 1'b0};
        end
    endgenerate

endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
    import rvx_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    logic [SHAMT_W-1:0] sh;

    always_comb begin
        sh = b[SHAMT_W-1:0];
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << sh;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, a < b};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> sh;
            ALU_SRA:  y = $unsigned($signed(a) >>> sh);
            ALU_OR:   y = a | b;
            ALU_AND:  y = a & b;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/rvx_br_cmp.sv
module rvx_br_cmp
    import rvx_pkg::*;
(
    input  logic [2:0]      f3,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            take,
    output logic            legal
);

    logic eq, lt_s, lt_u;

    always_comb begin
        eq    = (a == b);
        lt_s  = ($signed(a) < $signed(b));
        lt_u  = (a < b);
        legal = 1'b1;
        case (f3)
            3'b000:  take = eq;
            3'b001:  take = !eq;
            3'b100:  take = lt_s;
            3'b101:  take = !lt_s;
            3'b110:  take = lt_u;
            3'b111:  take = !lt_u;
            default: begin
                take  = 1'b0;
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rvx_exec_unit.sv
module rvx_exec_unit
    import rvx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ILEN-1:0]   instr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [XLEN-1:0]   rs2_val,
    output logic              rd_we,
    output logic [REG_AW-1:0] rd_addr,
    output logic [XLEN-1:0]   rd_data,
    output logic [XLEN-1:0]   next_pc,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              illegal
);

    logic [6:0]        opcode;
    logic [2:0]        f3;
    logic [6:0]        f7;
    logic [REG_AW-1:0] rd_idx;
    logic [XLEN-1:0]   imm_all [NUM_IMM];
    logic [XLEN-1:0]   pc_plus4;

    assign opcode   = instr[6:0];
    assign f3       = instr[14:12];
    assign f7       = instr[31:25];
    assign rd_idx   = instr[11:7];
    assign pc_plus4 = pc + XLEN'(4);

    // One immediate builder per format; the opcode picks among them.
    generate
        for (genvar k = 0; k < NUM_IMM; k++) begin : g_imm
            rvx_imm_gen #(.KIND(imm_kind_e'(k))) u_imm (
                .instr (instr),
                .imm   (imm_all[k])
            );
        end
    endgenerate

    // ALU operation select, shared by register and immediate forms.
    alu_op_e         alu_op;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            is_opimm;

    always_comb begin
        is_opimm = (opcode == OPC_OPIMM);
        alu_b    = is_opimm ? imm_all[IMM_I] : rs2_val;
        case (f3)
            3'b000:  alu_op = (!is_opimm && instr[30]) ? ALU_SUB : ALU_ADD;
            3'b001:  alu_op = ALU_SLL;
            3'b010:  alu_op = ALU_SLT;
            3'b011:  alu_op = ALU_SLTU;
            3'b100:  alu_op = ALU_XOR;
            3'b101:  alu_op = instr[30] ? ALU_SRA : ALU_SRL;
            3'b110:  alu_op = ALU_OR;
            default: alu_op = ALU_AND;
        endcase
    end

    rvx_alu u_alu (
        .op (alu_op),
        .a  (rs1_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    logic br_take, br_legal;

    rvx_br_cmp u_cmp (
        .f3    (f3),
        .a     (rs1_val),
        .b     (rs2_val),
        .take  (br_take),
        .legal (br_legal)
    );

    // Legality of the funct7 field for the arithmetic forms.
    logic op_legal, opimm_legal;

    always_comb begin
        op_legal = (f7 == F7_BASE) ||
                   ((f7 == F7_ALT) && (f3 == 3'b000 || f3 == 3'b101));
        case (f3)
            3'b001:  opimm_legal = (f7 == F7_BASE);
            3'b101:  opimm_legal = (f7 == F7_BASE) || (f7 == F7_ALT);
            default: opimm_legal = 1'b1;
        endcase
    end

    exec_res_t       res_d, res_q;
    logic            wr_en;
    logic [XLEN-1:0] wr_val;
    logic [XLEN-1:0] jr_target;

    always_comb begin
        res_d         = '0;
        res_d.next_pc = pc_plus4;
        wr_en         = 1'b0;
        wr_val        = '0;
        jr_target     = rs1_val + imm_all[IMM_I];
        case (opcode)
            OPC_OP: begin
                if (op_legal) begin
                    wr_en  = 1'b1;
                    wr_val = alu_y;
                end else begin
                    res_d.illegal = 1'b1;
                end
            end
            OPC_OPIMM: begin
                if (opimm_legal) begin
                    wr_en  = 1'b1;
                    wr_val = alu_y;
                end else begin
                    res_d.illegal = 1'b1;
                end
            end
            OPC_LUI: begin
                wr_en  = 1'b1;
                wr_val = imm_all[IMM_U];
            end
            OPC_AUIPC: begin
                wr_en  = 1'b1;
                wr_val = pc + imm_all[IMM_U];
            end
            OPC_JAL: begin
                wr_en         = 1'b1;
                wr_val        = pc_plus4;
                res_d.next_pc = pc + imm_all[IMM_J];
            end
            OPC_JALR: begin
                if (f3 == 3'b000) begin
                    wr_en         = 1'b1;
                    wr_val        = pc_plus4;
                    res_d.next_pc = {jr_target[XLEN-1:1], 1'b0};
                end else begin
                    res_d.illegal = 1'b1;
                end
            end
            OPC_BRANCH: begin
                if (br_legal) begin
                    if (br_take) begin
                        res_d.next_pc = pc + imm_all[IMM_B];
                    end
                end else begin
                    res_d.illegal = 1'b1;
                end
            end
            OPC_LOAD: begin
                if (f3 == F3_WORD) begin
                    wr_en          = 1'b1;
                    res_d.mem_rd   = 1'b1;
                    res_d.mem_addr = rs1_val + imm_all[IMM_I];
                end else begin
                    res_d.illegal = 1'b1;
                end
            end
            OPC_STORE: begin
                if (f3 == F3_WORD) begin
                    res_d.mem_wr    = 1'b1;
                    res_d.mem_addr  = rs1_val + imm_all[IMM_S];
                    res_d.mem_wdata = rs2_val;
                end else begin
                    res_d.illegal = 1'b1;
                end
            end
            default: res_d.illegal = 1'b1;
        endcase
        if (wr_en && (rd_idx != '0)) begin
            res_d.rd_we   = 1'b1;
            res_d.rd_addr = rd_idx;
            res_d.rd_data = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rd_we     = res_q.rd_we;
    assign rd_addr   = res_q.rd_addr;
    assign rd_data   = res_q.rd_data;
    assign next_pc   = res_q.next_pc;
    assign mem_rd    = res_q.mem_rd;
    assign mem_wr    = res_q.mem_wr;
    assign mem_addr  = res_q.mem_addr;
    assign mem_wdata = res_q.mem_wdata;
    assign illegal   = res_q.illegal;

endmodule

// File: rtl/rvx_exec_chk.sv
module rvx_exec_chk
    import rvx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ILEN-1:0]   instr,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   rs1_val,
    input logic [XLEN-1:0]   rs2_val,
    input logic              rd_we,
    input logic [REG_AW-1:0] rd_addr,
    input logic [XLEN-1:0]   rd_data,
    input logic [XLEN-1:0]   next_pc,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              illegal
);

    AST_X0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_addr != '0)); // R10

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!rd_we && !mem_rd && !mem_wr)); // R9

    AST_ILLEGAL_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && illegal) |-> (next_pc == $past(pc) + XLEN'(4))); // R11

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr})); // R8

    AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mem_wr) |-> (mem_wdata == $past(rs2_val))); // R8

    AST_UPPER_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[6:0]) == 7'b0110111 && $past(instr[11:7]) != 5'd0)
        |-> (rd_we && rd_data == {$past(instr[31:12]), 12'b0})); // R3

    AST_JUMP_REG_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr[6:0]) == 7'b1100111 && $past(instr[14:12]) == 3'b000)
        |-> (next_pc[0] == 1'b0)); // R6

endmodule

bind rvx_exec_unit rvx_exec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr     (instr),
    .pc        (pc),
    .rs1_val   (rs1_val),
    .rs2_val   (rs2_val),
    .rd_we     (rd_we),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .next_pc   (next_pc),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .illegal   (illegal)
);

// File: tb/tb_rvx_exec_unit.sv
`timescale 1ns/1ps
module tb_rvx_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] pc = 32'h0;
    logic [31:0] rs1_val = 32'h0;
    logic [31:0] rs2_val = 32'h0;
    logic        rd_we;
    logic [4:0]  rd_addr;
    logic [31:0] rd_data;
    logic [31:0] next_pc;
    logic        mem_rd;
    logic        mem_wr;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rvx_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc),
        .rs1_val(rs1_val), .rs2_val(rs2_val),
        .rd_we(rd_we), .rd_addr(rd_addr), .rd_data(rd_data),
        .next_pc(next_pc), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .illegal(illegal)
    );

    function automatic logic [31:0] opnd(input int k);
        case (k)
            0: return 32'h00000000;
            1: return 32'h00000001;
            2: return 32'hFFFFFFFF;
            3: return 32'h80000000;
            4: return 32'h7FFFFFFF;
            5: return 32'h0000001F;
            6: return 32'h12345678;
            default: return 32'hFFFFFFE0;
        endcase
    endfunction

    function automatic logic [31:0] sx12(input logic [11:0] v);
        return {{20{v[11]}}, v};
    endfunction
    function automatic logic [31:0] sx13(input logic [12:0] v);
        return {{19{v[12]}}, v};
    endfunction
    function automatic logic [31:0] sx21(input logic [20:0] v);
        return {{11{v[20]}}, v};
    endfunction

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
        input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
        return {f7, rs2, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
        input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [2:0] f3);
        return {imm[11:5], 5'd7, 5'd6, f3, imm[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [2:0] f3);
        return {imm[12], imm[10:5], 5'd4, 5'd3, f3, imm[4:1], imm[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] ref_alu(input logic [2:0] f3, input logic alt,
                                            input logic [31:0] a, input logic [31:0] b);
        logic [4:0] sh;
        sh = b[4:0];
        case (f3)
            3'd0: return alt ? a - b : a + b;
            3'd1: return a << sh;
            3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd3: return (a < b) ? 32'd1 : 32'd0;
            3'd4: return a ^ b;
            3'd5: return alt ? $unsigned($signed(a) >>> sh) : a >> sh;
            3'd6: return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic logic ref_br(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
        case (f3)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd4: return $signed(a) < $signed(b);
            3'd5: return $signed(a) >= $signed(b);
            3'd6: return a < b;
            default: return a >= b;
        endcase
    endfunction

    task automatic run(input logic [31:0] ins, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr = ins; pc = p; rs1_val = a; rs2_val = b;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic we, input logic [4:0] ra,
        input logic [31:0] rdat, input logic [31:0] npc, input logic mrd, input logic mwr,
        input logic [31:0] maddr, input logic [31:0] mwd, input logic ill);
        logic [136:0] got, exp;
        got = {rd_we, rd_addr, rd_data, next_pc, mem_rd, mem_wr, mem_addr, mem_wdata, illegal};
        exp = {we, ra, rdat, npc, mrd, mwr, maddr, mwd, ill};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s instr=%h got=%h exp=%h", tag, instr, got, exp);
        end
    endtask

    task automatic expect_wb(input string tag, input logic [4:0] rd,
                             input logic [31:0] val, input logic [31:0] npc);
        if (rd != 5'd0) expect_out(tag, 1'b1, rd, val, npc, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
        else            expect_out(tag, 1'b0, 5'd0, 32'h0, npc, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    endtask

    task automatic expect_ill(input string tag, input logic [31:0] p);
        expect_out(tag, 1'b0, 5'd0, 32'h0, p + 32'd4, 1'b0, 1'b0, 32'h0, 32'h0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] imm12;
        logic [4:0]  rd;
        logic [31:0] p, a, b;

        // R1: reset holds every output at zero
        instr = enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd3, 7'b0110011);
        rs1_val = 32'h5; rs2_val = 32'h6; pc = 32'h40;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4, R9: register ops over funct3, funct7 variants and operand corners
        for (int f3 = 0; f3 < 8; f3++) begin
            for (int v = 0; v < 3; v++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        logic [6:0] f7;
                        f7 = (v == 0) ? 7'h00 : (v == 1) ? 7'h20 : 7'h01;
                        rd = 5'((i * 4 + j) % 31 + 1);
                        p  = 32'h1000 + 32'(f3 * 256 + i * 16 + j * 4);
                        a  = opnd(i); b = opnd(j);
                        run(enc_r(f7, 5'd2, 5'd1, 3'(f3), rd, 7'b0110011), p, a, b);
                        if (v == 0 || (v == 1 && (f3 == 0 || f3 == 5)))
                            expect_wb("R4", rd, ref_alu(3'(f3), v == 1, a, b), p + 4);
                        else
                            expect_ill("R9 op-funct7", p);
                    end
                end
            end
        end

        // R10: x0 destination suppresses the write
        run(enc_r(7'h00, 5'd2, 5'd1, 3'd0, 5'd0, 7'b0110011), 32'h200, 32'h3, 32'h4);
        expect_wb("R10 op-x0", 5'd0, 32'h0, 32'h204);

        // R5: immediate ops
        for (int f3 = 0; f3 < 8; f3++) begin
            for (int i = 0; i < 8; i++) begin
                for (int k = 0; k < 6; k++) begin
                    logic alt;
                    case (k)
                        0: imm12 = 12'h000; 1: imm12 = 12'h001; 2: imm12 = 12'h7FF;
                        3: imm12 = 12'h800; 4: imm12 = 12'hFFF; default: imm12 = 12'h01F;
                    endcase
                    alt = 1'b0;
                    if (f3 == 1) imm12 = {7'h00, imm12[4:0]};
                    if (f3 == 5) begin
                        alt   = k[0];
                        imm12 = {alt ? 7'h20 : 7'h00, imm12[4:0]};
                    end
                    rd = 5'(i + k + 1);
                    p  = 32'h3000 + 32'(i * 64 + k * 4);
                    a  = opnd(i);
                    run(enc_i(imm12, 5'd1, 3'(f3), rd, 7'b0010011), p, a, 32'hDEADBEEF);
                    expect_wb("R5", rd, ref_alu(3'(f3), alt, a, sx12(imm12)), p + 4);
                end
            end
        end
        run(enc_i(12'h405, 5'd1, 3'd1, 5'd3, 7'b0010011), 32'h500, 32'h1, 32'h0);
        expect_ill("R9 slli-upper", 32'h500);
        run(enc_i(12'h025, 5'd1, 3'd5, 5'd3, 7'b0010011), 32'h504, 32'h1, 32'h0);
        expect_ill("R9 srli-upper", 32'h504);
        run(enc_i(12'hFFF, 5'd1, 3'd0, 5'd0, 7'b0010011), 32'h508, 32'h1, 32'h0);
        expect_wb("R10 addi-x0", 5'd0, 32'h0, 32'h50C);

        // R3: upper-immediate forms
        for (int k = 0; k < 5; k++) begin
            logic [19:0] u;
            case (k)
                0: u = 20'h00000; 1: u = 20'h80000; 2: u = 20'hFFFFF;
                3: u = 20'h12345; default: u = 20'h00001;
            endcase
            rd = (k == 4) ? 5'd0 : 5'(k + 8);
            p  = 32'hFFFF_F000 + 32'(k * 4);
            run({u, rd, 7'b0110111}, p, 32'h0, 32'h0);
            expect_wb("R3 R2 lui", rd, {u, 12'h0}, p + 4);
            run({u, rd, 7'b0010111}, p, 32'h0, 32'h0);
            expect_wb("R3 R2 auipc", rd, p + {u, 12'h0}, p + 4);
        end

        // R6, R2: jump with scattered offsets
        for (int k = 0; k < 6; k++) begin
            logic [20:0] off;
            case (k)
                0: off = 21'h000008; 1: off = 21'h1FFFFC; 2: off = 21'h0FFFFE;
                3: off = 21'h100000; 4: off = 21'h000800; default: off = 21'h001000;
            endcase
            rd = (k == 5) ? 5'd0 : 5'(k + 1);
            p  = 32'h0040_0000;
            run(enc_j(off, rd), p, 32'h0, 32'h0);
            expect_wb("R6 R2 jal", rd, p + 4, p + sx21(off));
        end

        // R6: jump-register clears bit 0
        run(enc_i(12'h000, 5'd1, 3'd0, 5'd1, 7'b1100111), 32'h100, 32'h0000_1001, 32'h0);
        expect_wb("R6 jalr-odd", 5'd1, 32'h104, 32'h0000_1000);
        run(enc_i(12'hFFF, 5'd1, 3'd0, 5'd5, 7'b1100111), 32'h200, 32'h0000_2000, 32'h0);
        expect_wb("R6 jalr-neg", 5'd5, 32'h204, 32'h0000_1FFE);
        run(enc_i(12'h7FF, 5'd1, 3'd0, 5'd0, 7'b1100111), 32'h300, 32'h8000_0000, 32'h0);
        expect_wb("R6 jalr-x0", 5'd0, 32'h0, 32'h8000_07FE);
        run(enc_i(12'h000, 5'd1, 3'd1, 5'd1, 7'b1100111), 32'h400, 32'h10, 32'h0);
        expect_ill("R9 jalr-f3", 32'h400);

        // R7, R2: branches over funct3, operand pairs and offsets
        for (int f3 = 0; f3 < 8; f3++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [12:0] off;
                    case (j)
                        0: off = 13'h0010; 1: off = 13'h1FF0; 2: off = 13'h0FFE;
                        3: off = 13'h1000; 4: off = 13'h0800; 5: off = 13'h07FE;
                        6: off = 13'h0002; default: off = 13'h1FFE;
                    endcase
                    p = 32'h0001_0000 + 32'(i * 32);
                    a = opnd(i); b = opnd(j);
                    run(enc_b(off, 3'(f3)), p, a, b);
                    if (f3 == 2 || f3 == 3)
                        expect_ill("R9 branch-f3", p);
                    else
                        expect_wb("R7 R2 branch", 5'd0, 32'h0,
                                  ref_br(3'(f3), a, b) ? p + sx13(off) : p + 4);
                end
            end
        end

        // R8, R9: loads and stores
        for (int f3 = 0; f3 < 8; f3++) begin
            for (int k = 0; k < 4; k++) begin
                case (k)
                    0: imm12 = 12'h004; 1: imm12 = 12'hFFC; 2: imm12 = 12'h7FF; default: imm12 = 12'h800;
                endcase
                a  = 32'h0002_0000 + 32'(k * 16);
                b  = opnd(k + 4);
                p  = 32'h0005_0000 + 32'(f3 * 16 + k * 4);
                rd = (k == 3) ? 5'd0 : 5'(k + 20);
                run(enc_i(imm12, 5'd1, 3'(f3), rd, 7'b0000011), p, a, b);
                if (f3 == 2)
                    expect_out("R8 load", rd != 0, rd, 32'h0, p + 4, 1, 0, a + sx12(imm12), 32'h0, 0);
                else
                    expect_ill("R9 load-width", p);
                run(enc_s(imm12, 3'(f3)), p, a, b);
                if (f3 == 2)
                    expect_out("R8 R2 store", 0, 0, 32'h0, p + 4, 0, 1, a + sx12(imm12), b, 0);
                else
                    expect_ill("R9 store-width", p);
            end
        end

        // R9: unknown opcodes
        for (int k = 0; k < 4; k++) begin
            logic [6:0] op;
            case (k)
                0: op = 7'b1110011; 1: op = 7'b0001111; 2: op = 7'b1111111; default: op = 7'b0000000;
            endcase
            run({25'h1ABCDE, op}, 32'h600 + 32'(k * 4), 32'h1, 32'h2);
            expect_ill("R9 opcode", 32'h600 + 32'(k * 4));
        end

        // R11: sequential address wraps modulo 2^32
        run(enc_r(7'h00, 5'd2, 5'd1, 3'd6, 5'd9, 7'b0110011), 32'hFFFF_FFFC, 32'hF0, 32'h0F);
        expect_wb("R11 wrap", 5'd9, 32'hFF, 32'h0000_0000);
        run(enc_b(13'h0040, 3'd0), 32'hFFFF_FFFC, 32'h1, 32'h2);
        expect_wb("R11 not-taken", 5'd0, 32'h0, 32'h0000_0000);
        run(enc_r(7'h01, 5'd2, 5'd1, 3'd0, 5'd9, 7'b0110011), 32'hFFFF_FFFC, 32'h3, 32'h3);
        expect_ill("R11 R9 mul", 32'hFFFF_FFFC);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule